// File: doc/BRIEF.md
# Dual-Port Parallel I/O Controller

This block connects a processor bus to two 8-bit parallel ports, A and B. The processor reaches each port through a port-select line and a control/data select line. On the control side it writes a short, stateful series of words that pick the port's mode, the pin directions, the interrupt match function, the interrupt mask and the interrupt vector. On the data side it writes the port's output register or reads a value that depends on the mode. Each port drives its pins through per-bit output enables and samples its input pins on every clock.

In bit-control mode each pin is an input or an output, set bit by bit. The port combines the sampled inputs with the output register, removes the masked bits, and tests the result with one of four AND/OR functions. A request is raised only when the match condition becomes true. It stays raised until an acknowledge pulse, and the acknowledge returns the vector of the highest-priority pending port on the data bus. Port A has priority over port B.

Bus cycles are synchronous. An access is taken on a rising clock edge while chip enable and I/O request are both high. A read returns its value on `dout` after that edge, and `dout` holds the value until the next read or acknowledge.

Top module: `dual_pio`

## Requirements
- R1: After reset, every port is in input mode (pins released, `port_oe` all 0, `port_out` all 1), its output register is 0x00, its interrupt enable is off, no request is pending, the control sequencer expects a command, and `dout` is 0x00.
- R2: A control write whose low nibble is 1111 is a mode word, and its bits 7:6 select the mode: 00 output, 01 input, 10 bidirectional, 11 bit control.
- R3: After a bit-control mode word, the next control write to that port is stored as the I/O-select register and is not decoded as a command, even if it looks like one. A 1 in this register makes that pin an input.
- R4: Interrupt and vector words:
  - A control write whose low nibble is 0111 is an interrupt word: bit 7 sets or clears the interrupt enable, bits 6:5 pick the match function, and bit 4 makes the next control write load the interrupt mask.
  - A 1 in the mask removes that bit from monitoring.
  - A command with bit 0 equal to 0 loads the port's 8-bit vector.
- R5: A data write loads the output register in output, input and bit-control modes. In bidirectional mode it leaves the output register unchanged.
- R6: Pin drive:
  - Output mode drives the output register on all pins.
  - Input and bidirectional modes release all pins and present all ones.
  - Bit-control mode drives the output-register bits on pins whose I/O-select bit is 0, releases the pins whose I/O-select bit is 1, and presents ones on them.
- R7: A data read returns, on `dout` after the edge that takes it:
  - in output mode, the output register;
  - in input mode, the sampled pins;
  - in bidirectional mode, 0xFF;
  - in bit-control mode, the sampled pins where I/O-select is 1 and the output register elsewhere.
- R8: In bit-control mode the monitored value is (sampled pins AND io_select) OR (output AND NOT io_select), with the masked bits removed. Function 00 matches when any monitored bit is low, 01 when any is high, 10 when all are low, and 11 when all are high.
- R9: A request is raised only when the match goes from false to true while the interrupt is enabled. A match that persists raises no second request. A register write that makes the match true raises a request in the same way as a pin change.
- R10: A raised request stays high until an acknowledge pulse. The acknowledge puts the vector of the pending port on `dout`, taking port A before port B, and clears only that port's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip enable |
| iorq | input | 1 | I/O request; an access needs both cs and iorq |
| rd | input | 1 | 1 = read access, 0 = write access |
| psel | input | 1 | Port select: 0 = A, 1 = B |
| cd | input | 1 | 1 = control word, 0 = data |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Registered read data or interrupt vector |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| port_in | input | 16 | Pin inputs; bits 7:0 port A, 15:8 port B |
| port_out | output | 16 | Pin output values; bits 7:0 port A, 15:8 port B |
| port_oe | output | 16 | Per-bit output enables, 1 = driven |
| port_irq | output | 2 | Interrupt requests; bit 0 port A, bit 1 port B |

## Verification
The bench builds the block with its default width of 8. At this width the command encodings (low nibbles 1111 and 0111, the mode field in bits 7:6) are fully defined, so every mode, every match function and the I/O-select value 0xF0 are all reachable. The value 0xF0 would otherwise decode as a vector load, which shows that the sequencer really consumes it as pin directions. Masked-bit cases and the two-port acknowledge order need both ports at full width, and the default provides that.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    MD_OUT   = 2'b00,
    MD_IN    = 2'b01,
    MD_BIDIR = 2'b10,
    MD_BIT   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SQ_CMD   = 2'b00,
    SQ_IOSEL = 2'b01,
    SQ_MASK  = 2'b10
  } seq_e;

  localparam logic [3:0] CODE_MODE = 4'b1111;
  localparam logic [3:0] CODE_INTW = 4'b0111;
endpackage

// File: rtl/pio_match.sv
module pio_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] pins_q,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] iosel,
  input  logic [W-1:0] imask,
  input  logic [1:0]   func,
  output logic         hit
);
  logic [W-1:0] watch;
  logic [W-1:0] value;

  always_comb begin
    watch = ~imask;
    value = ((pins_q & iosel) | (out_q & ~iosel)) & watch;
    unique case (func)
      2'b00:   hit = (value != watch);
      2'b01:   hit = (value != '0);
      2'b10:   hit = (value == '0);
      default: hit = (value == watch);
    endcase
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_ctrl,
  input  logic         wr_data,
  input  logic         ack_clr,
  input  logic [W-1:0] din,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         irq,
  output logic [W-1:0] vec
);
  mode_e        mode;
  seq_e         seq;
  logic [W-1:0] out_q, iosel, imask, pins_q;
  logic [1:0]   func;
  logic         ien, match_q, match_raw, match_now;

  pio_match #(.W(W)) u_match (
    .pins_q(pins_q), .out_q(out_q), .iosel(iosel),
    .imask(imask), .func(func), .hit(match_raw)
  );

  assign match_now = (mode == MD_BIT) && match_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MD_IN;
      seq     <= SQ_CMD;
      out_q   <= '0;
      iosel   <= '1;
      imask   <= '0;
      pins_q  <= '0;
      vec     <= '0;
      func    <= 2'b00;
      ien     <= 1'b0;
      match_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pins_q  <= pin_in;
      match_q <= match_now;
      if (match_now && !match_q && ien) irq <= 1'b1;
      else if (ack_clr)                 irq <= 1'b0;

      if (wr_data && mode != MD_BIDIR) out_q <= din;

      if (wr_ctrl) begin
        unique case (seq)
          SQ_IOSEL: begin
            iosel <= din;
            seq   <= SQ_CMD;
          end
          SQ_MASK: begin
            imask <= din;
            seq   <= SQ_CMD;
          end
          default: begin
            if (din[3:0] == CODE_MODE) begin
              mode <= mode_e'(din[7:6]);
              if (mode_e'(din[7:6]) == MD_BIT) seq <= SQ_IOSEL;
            end else if (din[3:0] == CODE_INTW) begin
              ien  <= din[7];
              func <= din[6:5];
              if (din[4]) seq <= SQ_MASK;
            end else if (!din[0]) begin
              vec <= din;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    unique case (mode)
      MD_OUT: begin
        pin_out = out_q;
        pin_oe  = '1;
        rd_val  = out_q;
      end
      MD_BIT: begin
        pin_out = (out_q & ~iosel) | iosel;
        pin_oe  = ~iosel;
        rd_val  = (pins_q & iosel) | (out_q & ~iosel);
      end
      MD_IN: begin
        pin_out = '1;
        pin_oe  = '0;
        rd_val  = pins_q;
      end
      default: begin
        pin_out = '1;
        pin_oe  = '0;
        rd_val  = '1;
      end
    endcase
  end

  AST_IOSEL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && seq == SQ_IOSEL) |=> (seq == SQ_CMD && iosel == $past(din))); // R3
  AST_MASK_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && seq == SQ_MASK) |=> (seq == SQ_CMD && imask == $past(din))); // R4
  AST_BIDIR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_data && mode == MD_BIDIR) |=> $stable(out_q)); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ien && mode == MD_BIT && !match_q)); // R9
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack_clr) |=> irq); // R10
endmodule

// File: rtl/dual_pio.sv
module dual_pio #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             iorq,
  input  logic             rd,
  input  logic             psel,
  input  logic             cd,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  input  logic             int_ack,
  input  logic [2*W-1:0]   port_in,
  output logic [2*W-1:0]   port_out,
  output logic [2*W-1:0]   port_oe,
  output logic [1:0]       port_irq
);
  localparam int NPORT = 2;

  logic             access, wr_any, rd_data;
  logic [W-1:0]     rd_val [NPORT];
  logic [W-1:0]     vec    [NPORT];
  logic [NPORT-1:0] ack_clr;
  logic             ack_hit;
  logic             ack_idx;

  assign access  = cs && iorq;
  assign wr_any  = access && !rd;
  assign rd_data = access && rd && !cd;

  always_comb begin
    ack_hit = 1'b0;
    ack_idx = 1'b0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (port_irq[i]) begin
        ack_hit = 1'b1;
        ack_idx = 1'(i);
      end
    end
  end

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_port
      assign ack_clr[g] = int_ack && ack_hit && (ack_idx == 1'(g));
      pio_port #(.W(W)) u_port (
        .clk(clk), .rst(rst),
        .wr_ctrl(wr_any && cd && (psel == 1'(g))),
        .wr_data(wr_any && !cd && (psel == 1'(g))),
        .ack_clr(ack_clr[g]),
        .din(din),
        .pin_in(port_in[g*W +: W]),
        .rd_val(rd_val[g]),
        .pin_out(port_out[g*W +: W]),
        .pin_oe(port_oe[g*W +: W]),
        .irq(port_irq[g]),
        .vec(vec[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                      dout <= '0;
    else if (int_ack && ack_hit)  dout <= vec[ack_idx];
    else if (rd_data)             dout <= rd_val[psel];
  end

  AST_ACK_A_FIRST: assert property (@(posedge clk) disable iff (rst)
    (int_ack && port_irq[0]) |=> (dout == $past(vec[0]))); // R10
  AST_ACK_B_NEXT: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !port_irq[0] && port_irq[1]) |=> (dout == $past(vec[1]))); // R10
endmodule

// File: tb/dual_pio_test.sv
module dual_pio_test;
  logic        clk = 1'b0;
  logic        rst, cs, iorq, rd, psel, cd, int_ack;
  logic [7:0]  din, dout;
  logic [15:0] port_in, port_out, port_oe;
  logic [1:0]  port_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_pio #(.W(8)) uut (
    .clk(clk), .rst(rst), .cs(cs), .iorq(iorq), .rd(rd), .psel(psel), .cd(cd),
    .din(din), .dout(dout), .int_ack(int_ack), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe), .port_irq(port_irq)
  );

  // op: 0 control write, 1 data write, 2 data read (exp), 3 pins (val=out, exp=oe)
  localparam int NV = 27;
  localparam logic [18:0] TBL [NV] = '{
    {2'd0, 1'b0, 8'h0F, 8'h00}, {2'd1, 1'b0, 8'h5A, 8'h00},
    {2'd2, 1'b0, 8'h00, 8'h5A}, {2'd3, 1'b0, 8'h5A, 8'hFF},
    {2'd0, 1'b0, 8'h4F, 8'h00}, {2'd2, 1'b0, 8'h00, 8'hA5},
    {2'd3, 1'b0, 8'hFF, 8'h00}, {2'd1, 1'b0, 8'h33, 8'h00},
    {2'd0, 1'b0, 8'h0F, 8'h00}, {2'd2, 1'b0, 8'h00, 8'h33},
    {2'd0, 1'b0, 8'h8F, 8'h00}, {2'd1, 1'b0, 8'h77, 8'h00},
    {2'd2, 1'b0, 8'h00, 8'hFF}, {2'd3, 1'b0, 8'hFF, 8'h00},
    {2'd0, 1'b0, 8'h0F, 8'h00}, {2'd2, 1'b0, 8'h00, 8'h33},
    {2'd0, 1'b0, 8'hCF, 8'h00}, {2'd0, 1'b0, 8'hF0, 8'h00},
    {2'd2, 1'b0, 8'h00, 8'hA3}, {2'd3, 1'b0, 8'hF3, 8'h0F},
    {2'd0, 1'b1, 8'h0F, 8'h00}, {2'd1, 1'b1, 8'hC3, 8'h00},
    {2'd2, 1'b1, 8'h00, 8'hC3}, {2'd3, 1'b1, 8'hC3, 8'hFF},
    {2'd2, 1'b0, 8'h00, 8'hA3}, {2'd0, 1'b1, 8'h4F, 8'h00},
    {2'd2, 1'b1, 8'h00, 8'h3C}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic p, input logic c, input logic [7:0] v);
    cs = 1; iorq = 1; rd = 0; psel = p; cd = c; din = v;
    @(negedge clk);
    cs = 0; iorq = 0;
  endtask

  task automatic rdchk(input logic p, input logic [7:0] exp, input string tag);
    cs = 1; iorq = 1; rd = 1; psel = p; cd = 0;
    @(negedge clk);
    cs = 0; iorq = 0; rd = 0;
    chk(tag, dout, exp);
  endtask

  task automatic ack();
    int_ack = 1;
    @(negedge clk);
    int_ack = 0;
  endtask

  function automatic bit mdl(input logic [1:0] f, input logic [7:0] v, input logic [7:0] m);
    logic [7:0] w, x;
    w = ~m; x = v & w;
    case (f)
      2'b00:   return x != w;
      2'b01:   return x != 0;
      2'b10:   return x == 0;
      default: return x == w;
    endcase
  endfunction

  task automatic setup_bit(input logic p, input logic [7:0] io, input logic [7:0] iw, input logic [7:0] m);
    wr(p, 1, 8'hCF); wr(p, 1, io); wr(p, 1, iw); wr(p, 1, m);
  endtask

  task automatic try_fn(input logic [1:0] f, input logic [7:0] p0, input logic [7:0] p1, input string tag);
    port_in[7:0] = p0;
    setup_bit(0, 8'hFF, {1'b1, f, 1'b1, 4'h7}, 8'hF0);
    idle(3); ack(); idle(2);
    chk({tag, " quiet before"}, {7'd0, port_irq[0]}, 8'd0);
    port_in[7:0] = p1;
    idle(3);
    chk(tag, {7'd0, port_irq[0]}, {7'd0, (!mdl(f, p0, 8'hF0) && mdl(f, p1, 8'hF0))});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; cs = 0; iorq = 0; rd = 0; psel = 0; cd = 0; din = 0; int_ack = 0;
    port_in = {8'h3C, 8'hA5};
    idle(3); rst = 0; idle(1);

    // R1 reset state
    chk("R1 oe", port_oe[7:0] | port_oe[15:8], 8'h00);
    chk("R1 out", port_out[7:0] & port_out[15:8], 8'hFF);
    chk("R1 irq", {6'd0, port_irq}, 8'h00);
    chk("R1 dout", dout, 8'h00);
    rdchk(0, 8'hA5, "R1 input mode read");
    wr(0, 1, 8'h0F);
    rdchk(0, 8'h00, "R1 output register cleared");

    // R2/R3/R5/R6/R7 vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic p; logic [7:0] v, e;
      {op, p, v, e} = TBL[i];
      case (op)
        2'd0: wr(p, 1, v);
        2'd1: wr(p, 0, v);
        2'd2: rdchk(p, e, $sformatf("R2/R5/R7 step %0d", i));
        default: begin
          chk($sformatf("R6 out step %0d", i), p ? port_out[15:8] : port_out[7:0], v);
          chk($sformatf("R6 oe step %0d", i),  p ? port_oe[15:8]  : port_oe[7:0],  e);
        end
      endcase
    end

    // R4 vectors, R8 functions
    wr(0, 1, 8'h20); wr(1, 1, 8'h40);
    try_fn(2'b00, 8'h0F, 8'h0E, "R8 any-low");
    try_fn(2'b01, 8'h00, 8'h08, "R8 any-high");
    try_fn(2'b10, 8'h01, 8'h00, "R8 all-low");
    try_fn(2'b11, 8'h07, 8'h0F, "R8 all-high");
    try_fn(2'b11, 8'h07, 8'h17, "R4 masked bit ignored");
    try_fn(2'b01, 8'h00, 8'h10, "R4 mask excludes bit4");

    // R9 persist, R10 hold and ack vector
    port_in[7:0] = 8'h00;
    setup_bit(0, 8'hFF, 8'hB7, 8'hF0);
    idle(3); ack(); idle(1);
    port_in[7:0] = 8'h01; idle(3);
    chk("R9 edge raises", {7'd0, port_irq[0]}, 8'd1);
    idle(5);
    chk("R10 request held", {7'd0, port_irq[0]}, 8'd1);
    ack();
    chk("R10 ack vector A", dout, 8'h20);
    chk("R10 ack clears A", {7'd0, port_irq[0]}, 8'd0);
    port_in[7:0] = 8'h03; idle(4);
    chk("R9 persistent no repeat", {7'd0, port_irq[0]}, 8'd0);

    // R9 disabled: no request
    port_in[7:0] = 8'h00;
    setup_bit(0, 8'hFF, 8'h37, 8'hF0);
    idle(3); ack(); idle(1);
    port_in[7:0] = 8'h02; idle(3);
    chk("R9 disabled no request", {7'd0, port_irq[0]}, 8'd0);

    // R9 register write creates match; R10 A before B
    wr(0, 0, 8'h00); wr(1, 0, 8'h00);
    setup_bit(0, 8'h00, 8'hB7, 8'hF0);
    setup_bit(1, 8'h00, 8'hB7, 8'hF0);
    idle(3); ack(); ack(); idle(2);
    chk("R9 quiet before write", {6'd0, port_irq}, 8'h00);
    wr(0, 0, 8'h04); wr(1, 0, 8'h02); idle(3);
    chk("R9 write raises both", {6'd0, port_irq}, 8'h03);
    ack();
    chk("R10 priority A vector", dout, 8'h20);
    chk("R10 B still pending", {6'd0, port_irq}, 8'h02);
    ack();
    chk("R10 then B vector", dout, 8'h40);
    chk("R10 all cleared", {6'd0, port_irq}, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule